// File: doc/BRIEF.md
# ECC Protected Byte-Lane Memory

A synchronous word memory of 16-bit entries that keeps every word as a 22-bit code word. The code is a single-error-correcting Hamming code with one extra overall parity bit. Every write goes through the encoder. A write to one byte lane is done as a read-modify-write: the old code word is decoded and corrected, the new byte is merged in, and all sixteen data bits are encoded again. Every read goes through the decoder. The decoder repairs a single flipped bit in the data it returns. It never writes the repaired value back into the array.

The access pins follow the classic asynchronous-memory style, with all selects active low except the second chip select. Two chip selects, a write strobe, an output enable and one enable per byte lane decide what happens on each clock edge. Read results arrive one clock after the request, qualified by `rvalid`. There is no ready input, so the consumer must take the result in the cycle it is shown and cannot apply back-pressure. Requests are accepted on every clock edge.

The error indication behaves like a three-state pin. It is split into a level (`err_flag`) and a drive enable (`err_oe`), and it is released whenever no read result is being shown. A sideband port flips one chosen code-word bit at one address, so that the correction path can be exercised.

Top module: `ecc_mem_core`

## Requirements
- R1: An access takes place only when `cs_a_n`=0, `cs_b`=1 and at least one of `lane_hi_n`/`lane_lo_n` is 0. Otherwise no read result appears and no word is changed.
- R2: A read with both lanes enabled returns the stored 16-bit word on `rdata` one clock after the request. In that cycle `rvalid`=1 and `rdata_en`=2'b11.
- R3: A single-lane read drives only that lane's byte and sets only its bit in `rdata_en`. Bit 0 is lanes 7:0 (from `lane_lo_n`) and bit 1 is lanes 15:8 (from `lane_hi_n`). The other byte of `rdata` reads as zero.
- R4: A single-lane write changes only that byte. The other byte keeps its value, corrected if its stored code word held a single-bit error, and the whole word is encoded afresh.
- R5: During a read result `err_oe`=1. `err_flag` is 0 for a clean word and 1 when a single-bit error was corrected. The returned data is the corrected value.
- R6: `err_oe`=0 and `rvalid`=0 in any cycle that does not follow a read request. This covers a deselected block, `oe_n`=1, and a write.
- R7: Correction is never written back, so a second read of the same corrupted word again gives `err_flag`=1.
- R8: A code word with two flipped bits gives `uncorr`=1 and `err_flag`=0 on its read.
- R9: With `inj_en`=1, the clock edge inverts code-word bit `inj_bit` (0 to 21, where bit 0 is the overall parity bit) at `inj_addr`. A write to the same address in the same cycle takes priority over the injection.
- R10: While `rst_n`=0 the outputs `rvalid`, `rdata_en`, `err_oe`, `err_flag` and `uncorr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| cs_a_n | input | 1 | First chip select, active low |
| cs_b | input | 1 | Second chip select, active high |
| wr_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| lane_hi_n | input | 1 | Upper byte lane enable, active low |
| lane_lo_n | input | 1 | Lower byte lane enable, active low |
| addr | input | AW | Word address |
| wdata | input | 16 | Write data |
| inj_en | input | 1 | Fault injection strobe |
| inj_addr | input | AW | Address of the word to corrupt |
| inj_bit | input | 5 | Code-word bit to invert |
| rdata | output | 16 | Read data, one clock after the request |
| rdata_en | output | 2 | Per-lane drive enables for `rdata` |
| rvalid | output | 1 | Read result qualifier |
| err_flag | output | 1 | 1 when a single-bit error was corrected |
| err_oe | output | 1 | Drive enable of `err_flag` |
| uncorr | output | 1 | Uncorrectable (double) error seen |

## Verification
The hardest states to reach from the ports are stored words that are already corrupted, because every normal write produces a clean code word. The stimulus creates them with the injection port. It flips a data bit, the overall parity bit alone, or two bits of one word, and then reads the word twice to show that nothing was written back. It also performs a single-lane write over a corrupted word, which checks that the merge keeps the corrected neighbour byte. Finally it injects into the same address in the same cycle as a write, to check which of the two takes priority.

// File: rtl/ecc_mem_pkg.sv
package ecc_mem_pkg;
  localparam int DATA_W    = 16;
  localparam int PAR_W     = 5;
  localparam int CW_W      = DATA_W + PAR_W + 1;
  localparam int LANE_W    = 8;
  localparam int NUM_LANES = DATA_W / LANE_W;
  localparam int BIT_IDX_W = $clog2(CW_W);

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [CW_W-1:0]   cw_t;

  function automatic logic is_pow2(input int v);
    return (v & (v - 1)) == 0;
  endfunction

  // Code-word position holding data bit k (positions 1.. skipping powers of two)
  function automatic int data_pos(input int k);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 1; p < CW_W; p++) begin
      if (!is_pow2(p)) begin
        if (cnt == k) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  // Positions covered by check bit i of the Hamming part
  function automatic cw_t col_mask(input int i);
    cw_t m;
    m = '0;
    for (int p = 1; p < CW_W; p++) m[p] = ((p >> i) & 1) == 1;
    return m;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import ecc_mem_pkg::*;
(
  input  word_t data_i,
  output cw_t   cw_o
);
  always_comb begin
    cw_t t;
    t = '0;
    for (int k = 0; k < DATA_W; k++) t[data_pos(k)] = data_i[k];
    for (int i = 0; i < PAR_W; i++) t[1 << i] = ^(t & col_mask(i));
    t[0] = ^t[CW_W-1:1];
    cw_o = t;
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import ecc_mem_pkg::*;
(
  input  cw_t   cw_i,
  output word_t data_o,
  output logic  single_o,
  output logic  double_o
);
  logic [PAR_W-1:0] syn;
  logic             ovr;
  logic             in_range;
  cw_t              fixed;

  always_comb begin
    for (int i = 0; i < PAR_W; i++) syn[i] = ^(cw_i & col_mask(i));
  end

  assign ovr      = ^cw_i;
  assign in_range = int'(syn) < CW_W;

  always_comb begin
    fixed = cw_i;
    if (ovr && in_range) fixed[syn] = ~cw_i[syn];
  end

  always_comb begin
    for (int k = 0; k < DATA_W; k++) data_o[k] = fixed[data_pos(k)];
  end

  assign single_o = ovr && in_range;
  assign double_o = (!ovr && (syn != '0)) || (ovr && !in_range);
endmodule

// File: rtl/ecc_mem_array.sv
module ecc_mem_array
  import ecc_mem_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  cw_t                  wcw,
  input  logic                 inj_en,
  input  logic [AW-1:0]        inj_addr,
  input  logic [BIT_IDX_W-1:0] inj_bit,
  input  logic [AW-1:0]        raddr,
  output cw_t                  rcw
);
  cw_t  mem [DEPTH];
  logic inj_go;

  assign inj_go = inj_en && (int'(inj_bit) < CW_W) && !(we && (waddr == inj_addr));

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wcw;
    if (inj_go) mem[inj_addr][inj_bit] <= ~mem[inj_addr][inj_bit];
  end

  assign rcw = mem[raddr];
endmodule

// File: rtl/ecc_mem_core.sv
module ecc_mem_core
  import ecc_mem_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_a_n,
  input  logic                 cs_b,
  input  logic                 wr_n,
  input  logic                 oe_n,
  input  logic                 lane_hi_n,
  input  logic                 lane_lo_n,
  input  logic [AW-1:0]        addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 inj_en,
  input  logic [AW-1:0]        inj_addr,
  input  logic [BIT_IDX_W-1:0] inj_bit,
  output logic [DATA_W-1:0]    rdata,
  output logic [NUM_LANES-1:0] rdata_en,
  output logic                 rvalid,
  output logic                 err_flag,
  output logic                 err_oe,
  output logic                 uncorr
);
  logic [NUM_LANES-1:0] lane_en;
  logic  sel, wr_go, rd_go;
  cw_t   old_cw, new_cw;
  word_t old_data, merged, masked;
  logic  old_single, old_double;

  assign lane_en = {~lane_hi_n, ~lane_lo_n};
  assign sel     = !cs_a_n && cs_b && (lane_en != '0);
  assign wr_go   = sel && !wr_n;
  assign rd_go   = sel && wr_n && !oe_n;

  ecc_mem_array #(.DEPTH(DEPTH)) u_array (
    .clk(clk), .we(wr_go), .waddr(addr), .wcw(new_cw),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_bit(inj_bit),
    .raddr(addr), .rcw(old_cw)
  );

  secded_dec u_dec (
    .cw_i(old_cw), .data_o(old_data),
    .single_o(old_single), .double_o(old_double)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign merged[l*LANE_W +: LANE_W] = lane_en[l] ? wdata[l*LANE_W +: LANE_W]
                                                   : old_data[l*LANE_W +: LANE_W];
    assign masked[l*LANE_W +: LANE_W] = lane_en[l] ? old_data[l*LANE_W +: LANE_W]
                                                   : '0;
  end

  secded_enc u_enc (.data_i(merged), .cw_o(new_cw));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rdata_en <= '0;
      rvalid   <= 1'b0;
      err_flag <= 1'b0;
      err_oe   <= 1'b0;
      uncorr   <= 1'b0;
    end else if (rd_go) begin
      rdata    <= masked;
      rdata_en <= lane_en;
      rvalid   <= 1'b1;
      err_flag <= old_single;
      err_oe   <= 1'b1;
      uncorr   <= old_double;
    end else begin
      rdata    <= '0;
      rdata_en <= '0;
      rvalid   <= 1'b0;
      err_flag <= 1'b0;
      err_oe   <= 1'b0;
      uncorr   <= 1'b0;
    end
  end
endmodule

// File: rtl/ecc_mem_core_chk.sv
module ecc_mem_core_chk
  import ecc_mem_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_a_n,
  input logic                 cs_b,
  input logic                 wr_n,
  input logic                 oe_n,
  input logic                 lane_hi_n,
  input logic                 lane_lo_n,
  input logic [DATA_W-1:0]    rdata,
  input logic [NUM_LANES-1:0] rdata_en,
  input logic                 rvalid,
  input logic                 err_flag,
  input logic                 err_oe,
  input logic                 uncorr
);
  logic rd_req;
  assign rd_req = !cs_a_n && cs_b && !(lane_hi_n && lane_lo_n) && wr_n && !oe_n;

  p_read_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rvalid && err_oe);

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !err_oe && !rvalid && (rdata_en == '0));

  p_lane_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rdata_en == $past({~lane_hi_n, ~lane_lo_n}));

  p_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rdata_en[1]) |-> rdata[15:8] == 8'h00);

  p_lo_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rdata_en[0]) |-> rdata[7:0] == 8'h00);

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> err_oe && !uncorr);
endmodule

bind ecc_mem_core ecc_mem_core_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b(cs_b), .wr_n(wr_n),
  .oe_n(oe_n), .lane_hi_n(lane_hi_n), .lane_lo_n(lane_lo_n),
  .rdata(rdata), .rdata_en(rdata_en), .rvalid(rvalid),
  .err_flag(err_flag), .err_oe(err_oe), .uncorr(uncorr)
);

// File: tb/ecc_mem_core_test.sv
module ecc_mem_core_test;
  localparam int CLK_P = 10;
  localparam int AW    = 6;

  typedef struct packed {
    logic        wr;
    logic [1:0]  lanes;
    logic [5:0]  addr;
    logic [15:0] data;
    logic [15:0] exp;
    logic [1:0]  exp_en;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'b11, 6'd1, 16'h1234, 16'h0000, 2'b00},
    '{1'b1, 2'b11, 6'd2, 16'hA5C3, 16'h0000, 2'b00},
    '{1'b1, 2'b11, 6'd3, 16'h0FF0, 16'h0000, 2'b00},
    '{1'b0, 2'b11, 6'd1, 16'h0000, 16'h1234, 2'b11},
    '{1'b0, 2'b01, 6'd2, 16'h0000, 16'h00C3, 2'b01},
    '{1'b0, 2'b10, 6'd3, 16'h0000, 16'h0F00, 2'b10},
    '{1'b1, 2'b01, 6'd2, 16'h0077, 16'h0000, 2'b00},
    '{1'b0, 2'b11, 6'd2, 16'h0000, 16'hA577, 2'b11},
    '{1'b1, 2'b10, 6'd3, 16'h9900, 16'h0000, 2'b00},
    '{1'b0, 2'b11, 6'd3, 16'h0000, 16'h99F0, 2'b11},
    '{1'b0, 2'b10, 6'd1, 16'h0000, 16'h1200, 2'b10}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_a_n = 1'b1, cs_b = 1'b0, wr_n = 1'b1, oe_n = 1'b1;
  logic lane_hi_n = 1'b1, lane_lo_n = 1'b1;
  logic [AW-1:0] addr = '0, inj_addr = '0;
  logic [15:0] wdata = '0;
  logic inj_en = 1'b0;
  logic [4:0] inj_bit = '0;
  logic [15:0] rdata;
  logic [1:0] rdata_en;
  logic rvalid, err_flag, err_oe, uncorr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ecc_mem_core #(.DEPTH(64)) uut (
    .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b(cs_b), .wr_n(wr_n),
    .oe_n(oe_n), .lane_hi_n(lane_hi_n), .lane_lo_n(lane_lo_n), .addr(addr),
    .wdata(wdata), .inj_en(inj_en), .inj_addr(inj_addr), .inj_bit(inj_bit),
    .rdata(rdata), .rdata_en(rdata_en), .rvalid(rvalid),
    .err_flag(err_flag), .err_oe(err_oe), .uncorr(uncorr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic access(input logic w, input logic [1:0] lanes, input logic [AW-1:0] a,
                        input logic [15:0] d);
    cs_a_n = 1'b0; cs_b = 1'b1; wr_n = ~w; oe_n = 1'b0;
    lane_hi_n = ~lanes[1]; lane_lo_n = ~lanes[0];
    addr = a; wdata = d; inj_en = 1'b0;
    tick();
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [4:0] b);
    cs_a_n = 1'b1; cs_b = 1'b0; inj_en = 1'b1; inj_addr = a; inj_bit = b;
    tick();
    inj_en = 1'b0;
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 rvalid", rvalid, 0);
    chk("R10 err_oe", err_oe, 0);
    chk("R10 flags", {rdata_en, err_flag, uncorr}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].lanes, VECS[i].addr, VECS[i].data);
      if (!VECS[i].wr) begin
        string tag;
        tag = (VECS[i].lanes != 2'b11) ? "R3" : ((i == 7 || i == 9) ? "R4" : "R2");
        chk({tag, " data"}, rdata, VECS[i].exp);
        chk({tag, " lane en"}, rdata_en, VECS[i].exp_en);
        chk({tag, " valid"}, {rvalid, err_oe, err_flag}, 3'b110);
      end else begin
        chk("R6 write releases err", {err_oe, rvalid}, 0);
      end
    end

    // R5/R9/R7: single data-bit injection, no write-back
    inject(6'd1, 5'd7);
    access(1'b0, 2'b11, 6'd1, 16'h0);
    chk("R5 corrected data", rdata, 16'h1234);
    chk("R5 err flag set", {err_oe, err_flag, uncorr}, 3'b110);
    access(1'b0, 2'b11, 6'd1, 16'h0);
    chk("R7 flag again", err_flag, 1);
    // R4: lane write over corrupted word keeps corrected upper byte
    access(1'b1, 2'b01, 6'd1, 16'h0055);
    access(1'b0, 2'b11, 6'd1, 16'h0);
    chk("R4 merged", rdata, 16'h1255);
    chk("R4 re-encoded clean", err_flag, 0);

    // R9: overall parity bit flip
    inject(6'd2, 5'd0);
    access(1'b0, 2'b11, 6'd2, 16'h0);
    chk("R9 parity-bit data", rdata, 16'hA577);
    chk("R9 parity-bit flag", err_flag, 1);

    // R8: double error
    inject(6'd3, 5'd3);
    inject(6'd3, 5'd12);
    access(1'b0, 2'b11, 6'd3, 16'h0);
    chk("R8 uncorr", {uncorr, err_flag}, 2'b10);

    // R1: deselect variants
    access(1'b1, 2'b11, 6'd5, 16'h3C3C);
    cs_a_n = 1'b1; cs_b = 1'b1; wr_n = 1'b0; oe_n = 1'b0; lane_hi_n = 1'b0; lane_lo_n = 1'b0;
    addr = 6'd5; wdata = 16'hFFFF;
    tick();
    chk("R1 cs_a_n high", rvalid, 0);
    cs_a_n = 1'b0; cs_b = 1'b0;
    tick();
    cs_b = 1'b1; lane_hi_n = 1'b1; lane_lo_n = 1'b1;
    tick();
    wr_n = 1'b1;
    tick();
    chk("R1 lanes off no read", {rvalid, err_oe}, 0);
    access(1'b0, 2'b11, 6'd5, 16'h0);
    chk("R1 word unchanged", rdata, 16'h3C3C);

    // R6: output enable high
    cs_a_n = 1'b0; cs_b = 1'b1; wr_n = 1'b1; oe_n = 1'b1; lane_hi_n = 1'b0; lane_lo_n = 1'b0;
    tick();
    chk("R6 oe high", {rvalid, err_oe}, 0);

    // R9: write wins over same-cycle injection
    cs_a_n = 1'b0; cs_b = 1'b1; wr_n = 1'b0; oe_n = 1'b0; addr = 6'd6; wdata = 16'hBEEF;
    inj_en = 1'b1; inj_addr = 6'd6; inj_bit = 5'd5;
    tick();
    inj_en = 1'b0;
    access(1'b0, 2'b11, 6'd6, 16'h0);
    chk("R9 write priority", {rdata, err_flag}, {16'hBEEF, 1'b0});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule